// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block decides, line by line, when an interline CCD sensor gets a substrate discharge pulse (which empties the photodiodes and so sets the start of exposure) and when the readout transfer into the vertical registers is allowed. It follows frame and line sync strobes from the sync generator and counts pixel clocks inside each line to place the discharge pulses. The outputs are single-bit requests that a later stage shapes into analog drive levels.

Software supplies a configuration word: a shutter mode, a frame count, a line position, a drive mode and an exposure bit. Exposure time has two parts. The frame count sets how many whole frames readout is withheld. The line position sets the last line of a readout frame that still carries discharge pulses. In monitoring drive mode the line position is offset by half a frame, so a given setting gives about the same exposure in either drive mode. Illegal line positions are clamped and flagged. While a frame count is running the block reports busy and refuses new configuration.

Line index 0 of a frame is the readout line. Lines are counted from the frame sync. A frame sync always comes together with a line sync.

Top module: `ccd_shutter_seq`

## Requirements
- R1: After reset, and until the first frame sync, vsubOut, readoutEn, busy and cfgErr are all low.
- R2: In shutter modes 00, 01 and 10, readoutEn is high for the whole of line index 0 of every readout frame. It is low on every other line.
- R3: In mode 01, each line with index 1 up to the effective stop line of a readout frame carries a VSUB pulse. The pulse is high for pixel clocks PULSE_START to PULSE_START+PULSE_W-1 after that line's sync.
- R4: The effective stop line equals the line field in recording mode (recordMode=1). In monitoring mode it equals the line field minus OFFSET, where OFFSET=(FRAME_LINES-1)/2, which is 262 by default.
- R5: In monitoring mode, mode 01 lines of even fields carry a second pulse over pixel clocks PULSE_START+2*PULSE_W to PULSE_START+3*PULSE_W-1. Odd fields and recording mode get only one pulse. The first frame after reset is odd, and parity alternates on every frame sync.
- R6: Modes 00 and 10 (stopped) produce no shutter pulses. Every frame is a readout frame, and the frame and line fields have no effect.
- R7: Mode 11 suppresses readoutEn and all VSUB pulses in every frame.
- R8: In mode 01 with frame count N>0, each readout frame is followed by N frames with neither readout nor VSUB. busy rises at the readout frame sync and falls at the sync of the last held frame.
- R9: A cfgLoad pulse while busy is high is ignored. Output behaviour and cfgErr stay unchanged.
- R10: When the exposure bit is set, line index 1 of a readout frame carries one VSUB pulse in any mode except 11, stopped modes included.
- R11: On an accepted load, a line field above FRAME_LINES-1 is clamped to FRAME_LINES-1. In monitoring mode a field of OFFSET or less is clamped to OFFSET+1. cfgErr then shows whether that load was clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | One-cycle frame start strobe, coincident with lineSync |
| lineSync | input | 1 | One-cycle line start strobe |
| cfgLoad | input | 1 | Applies the configuration fields on this cycle |
| shutMode | input | 2 | Shutter mode: 00/10 stopped, 01 shutter, 11 readout hold |
| frameCount | input | FRAME_W | Number of frames readout is withheld |
| lineCount | input | LINE_W | Line position where discharge pulses end |
| recordMode | input | 1 | 1 recording drive, 0 monitoring drive |
| exposeReq | input | 1 | Forces one discharge pulse after readout |
| vsubOut | output | 1 | Substrate discharge pulse request |
| readoutEn | output | 1 | Readout transfer enable for the current line |
| busy | output | 1 | Frame count running, configuration refused |
| cfgErr | output | 1 | Last accepted line field was clamped |

## Verification
Some properties are checked on every cycle: a refused load leaves the stored configuration unchanged, a held frame never enables readout, the stored stop line stays in range and is nonzero in monitoring shutter mode, readout and discharge never coincide, and the second pulse window occurs only on dual-pulse lines. Other behaviours need whole frames to show: the exact pulse positions, field parity, the length of the frame count hold and when busy falls, the clamping results, and the interplay of the exposure bit with each mode. The bench's frame-level scenarios with a reference model cover these.

// File: rtl/ccd_shutter_pkg.sv
package ccd_shutter_pkg;
  typedef struct packed {
    logic lineStart;  // pixel counter restart
    logic readLine;   // readout allowed on this line
    logic vsubLine;   // this line carries a discharge pulse
    logic dualPulse;  // add the second pulse window
  } lineCtlT;
endpackage

// File: rtl/ccd_shutter_ctrl.sv
module ccd_shutter_ctrl
  import ccd_shutter_pkg::*;
#(
  parameter int FRAME_W     = 8,
  parameter int LINE_W      = 10,
  parameter int FRAME_LINES = 525
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameSync,
  input  logic               lineSync,
  input  logic               cfgLoad,
  input  logic [1:0]         shutMode,
  input  logic [FRAME_W-1:0] frameCount,
  input  logic [LINE_W-1:0]  lineCount,
  input  logic               recordMode,
  input  logic               exposeReq,
  output lineCtlT            lineCtl,
  output logic               busy,
  output logic               cfgErr
);
  localparam logic [LINE_W-1:0] LAST_L = LINE_W'(FRAME_LINES - 1);
  localparam logic [LINE_W-1:0] OFF_L  = LINE_W'((FRAME_LINES - 1) / 2);
  localparam logic [1:0] MODE_SHUT = 2'b01;
  localparam logic [1:0] MODE_HOLD = 2'b11;

  logic [1:0]         actMode;
  logic [FRAME_W-1:0] actFrames;
  logic [LINE_W-1:0]  actStop;
  logic               actRec, actExpose;
  logic [FRAME_W-1:0] holdCnt;
  logic               readFrame, oddField;
  logic [LINE_W-1:0]  lineIdx;

  // clamp and offset of the requested line position
  logic [LINE_W-1:0] lineSat, lineFix, stopNext;
  logic              errNext;
  always_comb begin
    errNext = 1'b0;
    lineSat = lineCount;
    if (lineCount > LAST_L) begin
      lineSat = LAST_L;
      errNext = 1'b1;
    end
    lineFix = lineSat;
    if (!recordMode && lineSat <= OFF_L) begin
      lineFix = OFF_L + 1'b1;
      errNext = 1'b1;
    end
    stopNext = recordMode ? lineFix : lineFix - OFF_L;
  end

  wire acceptCfg = cfgLoad && (holdCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actMode   <= 2'b00;
      actFrames <= '0;
      actStop   <= '0;
      actRec    <= 1'b0;
      actExpose <= 1'b0;
      cfgErr    <= 1'b0;
    end else if (acceptCfg) begin
      actMode   <= shutMode;
      actFrames <= frameCount;
      actStop   <= stopNext;
      actRec    <= recordMode;
      actExpose <= exposeReq;
      cfgErr    <= errNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt   <= '0;
      readFrame <= 1'b0;
      oddField  <= 1'b0;
      lineIdx   <= '1;
    end else if (frameSync) begin
      lineIdx  <= '0;
      oddField <= !oddField;
      if (holdCnt == '0) begin
        readFrame <= 1'b1;
        holdCnt   <= (actMode == MODE_SHUT) ? actFrames : '0;
      end else begin
        readFrame <= 1'b0;
        holdCnt   <= holdCnt - 1'b1;
      end
    end else if (lineSync && lineIdx != '1) begin
      lineIdx <= lineIdx + 1'b1;
    end
  end

  logic shutterOn, exposeHit;
  always_comb begin
    shutterOn = readFrame && (actMode == MODE_SHUT) &&
                (lineIdx >= LINE_W'(1)) && (lineIdx <= actStop);
    exposeHit = readFrame && actExpose && (actMode != MODE_HOLD) &&
                (lineIdx == LINE_W'(1));
    lineCtl.lineStart = lineSync;
    lineCtl.readLine  = readFrame && (lineIdx == '0) && (actMode != MODE_HOLD);
    lineCtl.vsubLine  = shutterOn || exposeHit;
    lineCtl.dualPulse = shutterOn && !actRec && !oddField;
  end

  assign busy = (holdCnt != '0);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && busy) |=> ($stable(actStop) && $stable(actMode) && $stable(actFrames)));
  // R8
  held_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && busy) |=> !readFrame);
  // R11
  stop_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    actStop <= LAST_L);
  // R4
  mon_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actMode == MODE_SHUT && !actRec) |-> (actStop != '0));
endmodule

// File: rtl/ccd_shutter_dp.sv
module ccd_shutter_dp
  import ccd_shutter_pkg::*;
#(
  parameter int LINE_CLKS   = 780,
  parameter int PULSE_START = 16,
  parameter int PULSE_W     = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  lineCtlT lineCtl,
  output logic    vsubOut,
  output logic    readoutEn
);
  localparam int PIX_W = $clog2(LINE_CLKS + 1);
  localparam logic [PIX_W-1:0] W0_LO = PIX_W'(PULSE_START);
  localparam logic [PIX_W-1:0] W0_HI = PIX_W'(PULSE_START + PULSE_W);
  localparam logic [PIX_W-1:0] W1_LO = PIX_W'(PULSE_START + 2 * PULSE_W);
  localparam logic [PIX_W-1:0] W1_HI = PIX_W'(PULSE_START + 3 * PULSE_W);

  logic [PIX_W-1:0] pixCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                pixCnt <= '1;
    else if (lineCtl.lineStart) pixCnt <= '0;
    else if (pixCnt != '1)    pixCnt <= pixCnt + 1'b1;
  end

  logic inFirst, inSecond;
  always_comb begin
    inFirst   = (pixCnt >= W0_LO) && (pixCnt < W0_HI);
    inSecond  = (pixCnt >= W1_LO) && (pixCnt < W1_HI);
    vsubOut   = lineCtl.vsubLine && (inFirst || (lineCtl.dualPulse && inSecond));
    readoutEn = lineCtl.readLine;
  end

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(vsubOut && readoutEn));
  // R5
  second_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vsubOut && pixCnt >= W1_LO) |-> lineCtl.dualPulse);
endmodule

// File: rtl/ccd_shutter_seq.sv
module ccd_shutter_seq
  import ccd_shutter_pkg::*;
#(
  parameter int FRAME_W     = 8,
  parameter int LINE_W      = 10,
  parameter int FRAME_LINES = 525,
  parameter int LINE_CLKS   = 780,
  parameter int PULSE_START = 16,
  parameter int PULSE_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameSync,
  input  logic               lineSync,
  input  logic               cfgLoad,
  input  logic [1:0]         shutMode,
  input  logic [FRAME_W-1:0] frameCount,
  input  logic [LINE_W-1:0]  lineCount,
  input  logic               recordMode,
  input  logic               exposeReq,
  output logic               vsubOut,
  output logic               readoutEn,
  output logic               busy,
  output logic               cfgErr
);
  lineCtlT lineCtl;

  ccd_shutter_ctrl #(
    .FRAME_W(FRAME_W), .LINE_W(LINE_W), .FRAME_LINES(FRAME_LINES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .lineSync(lineSync),
    .cfgLoad(cfgLoad), .shutMode(shutMode), .frameCount(frameCount),
    .lineCount(lineCount), .recordMode(recordMode), .exposeReq(exposeReq),
    .lineCtl(lineCtl), .busy(busy), .cfgErr(cfgErr)
  );

  ccd_shutter_dp #(
    .LINE_CLKS(LINE_CLKS), .PULSE_START(PULSE_START), .PULSE_W(PULSE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineCtl(lineCtl),
    .vsubOut(vsubOut), .readoutEn(readoutEn)
  );
endmodule

// File: tb/tb_ccd_shutter_seq.sv
module tb_ccd_shutter_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 8;
  localparam int LW = 10;
  localparam int NLINES = 16;
  localparam int LCLK = 32;
  localparam int PS = 4;
  localparam int PW = 8;
  localparam int OFFSET = (NLINES - 1) / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0, lineSync = 1'b0, cfgLoad = 1'b0;
  logic [1:0] shutMode = 2'b00;
  logic [FW-1:0] frameCount = '0;
  logic [LW-1:0] lineCount = '0;
  logic recordMode = 1'b0, exposeReq = 1'b0;
  logic vsubOut, readoutEn, busy, cfgErr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int mMode = 0, mFrames = 0, mStop = 0, mHold = 0;
  bit mRec = 0, mExp = 0, mErr = 0, mRead = 0, mOdd = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccd_shutter_seq #(
    .FRAME_W(FW), .LINE_W(LW), .FRAME_LINES(NLINES), .LINE_CLKS(LCLK),
    .PULSE_START(PS), .PULSE_W(PW)
  ) dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .lineSync(lineSync),
    .cfgLoad(cfgLoad), .shutMode(shutMode), .frameCount(frameCount),
    .lineCount(lineCount), .recordMode(recordMode), .exposeReq(exposeReq),
    .vsubOut(vsubOut), .readoutEn(readoutEn), .busy(busy), .cfgErr(cfgErr)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int stopOf(input int ln, input bit rec);
    int v = (ln > NLINES - 1) ? NLINES - 1 : ln;
    if (!rec && v <= OFFSET) v = OFFSET + 1;
    return rec ? v : v - OFFSET;
  endfunction

  function automatic bit errOf(input int ln, input bit rec);
    return (ln > NLINES - 1) || (!rec && ln <= OFFSET);
  endfunction

  function automatic bit expVsub(input int ln, input int p);
    bit shut = mRead && mMode == 1 && ln >= 1 && ln <= mStop;
    bit expo = mRead && mExp && mMode != 3 && ln == 1;
    bit w0 = p >= PS && p < PS + PW;
    bit w1 = p >= PS + 2 * PW && p < PS + 3 * PW;
    return (shut || expo) && (w0 || (shut && !mRec && !mOdd && w1));
  endfunction

  function automatic string vsubTag(input int ln, input int p);
    if (mExp && ln == 1) return "R10";
    if (mMode == 3) return "R7";
    if (mMode != 1) return "R6";
    if (!mRead) return "R8";
    if (p >= PS + 2 * PW) return "R5";
    if (!mRec) return "R4";
    return "R3";
  endfunction

  task automatic runFrame();
    if (mHold == 0) begin
      mRead = 1;
      mHold = (mMode == 1) ? mFrames : 0;
    end else begin
      mRead = 0;
      mHold = mHold - 1;
    end
    mOdd = !mOdd;
    for (int ln = 0; ln < NLINES; ln++) begin
      lineSync = 1'b1;
      frameSync = (ln == 0);
      @(posedge clk);
      for (int p = 0; p < LCLK; p++) begin
        @(negedge clk);
        lineSync = 1'b0;
        frameSync = 1'b0;
        check(vsubTag(ln, p), vsubOut, expVsub(ln, p), "vsub");
        check(mMode == 3 ? "R7" : "R2", readoutEn,
              (mRead && ln == 0 && mMode != 3) ? 1 : 0, "readout");
        check("R8", busy, (mHold != 0) ? 1 : 0, "busy");
        if (p != LCLK - 1) @(posedge clk);
      end
    end
  endtask

  task automatic loadCfg(input int md, input int fr, input int ln, input bit rec, input bit ex);
    bit accepted;
    shutMode = 2'(md);
    frameCount = FW'(fr);
    lineCount = LW'(ln);
    recordMode = rec;
    exposeReq = ex;
    cfgLoad = 1'b1;
    accepted = (mHold == 0);
    @(posedge clk);
    @(negedge clk);
    cfgLoad = 1'b0;
    if (accepted) begin
      mMode = md; mFrames = fr; mRec = rec; mExp = ex;
      mStop = stopOf(ln, rec);
      mErr = errOf(ln, rec);
    end
    check(accepted ? "R11" : "R9", cfgErr, mErr, "cfgErr");
    check("R8", busy, (mHold != 0) ? 1 : 0, "busy");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      // R1: quiet until the first frame sync
      check("R1", vsubOut, 0, "vsub");
      check("R1", readoutEn, 0, "readout");
      check("R1", busy, 0, "busy");
      check("R1", cfgErr, 0, "cfgErr");
    end
    runFrame();                       // R6 default stopped mode
    loadCfg(1, 0, 5, 1, 0);  runFrame(); runFrame();   // R3 recording
    loadCfg(1, 0, 10, 0, 0); runFrame(); runFrame();   // R4 R5 monitoring
    loadCfg(1, 0, 3, 0, 0);  runFrame();               // R11 low clamp
    loadCfg(1, 0, 20, 1, 0); runFrame();               // R11 high clamp
    loadCfg(0, 3, 9, 1, 1);  runFrame();               // R10 in stopped mode
    loadCfg(2, 0, 9, 0, 0);  runFrame();               // R6 mode 10
    loadCfg(3, 0, 9, 1, 1);  runFrame();               // R7
    loadCfg(1, 2, 6, 1, 0);  runFrame();               // R8 start hold
    loadCfg(0, 0, 0, 0, 1);                            // R9 refused
    runFrame(); runFrame(); runFrame();
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 2) != 0)
        loadCfg($urandom_range(0, 3), ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0,
                $urandom_range(0, 20), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      runFrame();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule